// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single input line. A phase-accumulator rate generator, set by a 16-bit rate word, produces a tick at sixteen times the bit rate. The line is synchronised, optionally cleaned by a three-sample majority vote, and then framed by a receive state machine. The framing is one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Each completed character is presented on a byte output with a one-cycle valid strobe. Parity and stop-bit errors are reported as pulses in the same cycle as that strobe.

A separate counter watches for a break, which is the line held low for a programmable number of character times. A sixteen-bit register keeps the most recent oversampled values of the line as the receiver sees it. A line-loopback mode forwards the raw input to a loop output, and while it is active the receiver sees a permanently idle line. Buffering, bus access and transmission belong to neighbouring blocks.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, idle_o is 1, valid_o, par_err_o, frm_err_o and brk_o are 0, and hist_o is 16'hFFFF.
- R2: A character has a low start bit, then 8 data bits with the LSB first, then an optional parity bit, then a stop bit. Each bit lasts 16 ticks. The start bit is confirmed at its middle, and every later bit is sampled 16 ticks after the previous sample. When the stop bit has been sampled, data_o holds the byte and valid_o is high for exactly one cycle.
- R3: A 16-bit accumulator adds rate_i on every clock, and each carry out is one oversample tick. With rate_i = 16'h8000 there is one tick every two clocks, so a bit lasts 32 clocks.
- R4: When par_en_i is 1, a parity bit follows the data. Its expected value is the XOR of the 8 data bits, XORed with par_odd_i (1 selects odd parity, 0 selects even). A mismatch raises par_err_o together with valid_o. When par_en_i is 0, no parity bit is expected and par_err_o stays 0.
- R5: A stop bit sampled low raises frm_err_o together with valid_o. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: If the line stays low for N character times (N = 2, 4, 8, 16 for brk_lvl_i = 0, 1, 2, 3; one character time is 160 ticks), brk_o pulses for one cycle. It pulses only once until the line has gone high again.
- R7: With filt_en_i = 1, a low glitch lasting one clock is ignored and idle_o stays 1. With filt_en_i = 0, the same glitch starts a reception. That reception is dropped at the mid-start check, without valid_o.
- R8: On every tick, hist_o shifts left and takes the receiver's view of the line into bit 0, so bit 0 is the newest sample and bit 15 the oldest.
- R9: While lpbk_en_i is 1, the receiver sees the line as 1 and lpbk_tx_o equals line_i. While lpbk_en_i is 0, lpbk_tx_o is 1.
- R10: While rx_en_i is 0, no character is received, idle_o is 1 and the break count is cleared.
- R11: idle_o is low from the detection of a start bit until the character has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| line_i | input | 1 | Asynchronous serial input |
| filt_en_i | input | 1 | Majority glitch filter enable |
| lpbk_en_i | input | 1 | Line loopback enable |
| par_en_i | input | 1 | Parity bit expected |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| brk_lvl_i | input | 2 | Break length code (2, 4, 8, 16 characters) |
| rate_i | input | 16 | Rate word added to the accumulator each clock |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | One-cycle strobe for data_o |
| par_err_o | output | 1 | Parity error pulse, with valid_o |
| frm_err_o | output | 1 | Stop-bit error pulse, with valid_o |
| brk_o | output | 1 | Break detected pulse |
| idle_o | output | 1 | No character in progress |
| hist_o | output | 16 | Last 16 oversampled line values, newest in bit 0 |
| lpbk_tx_o | output | 1 | Line value forwarded in loopback |

## Verification
A bit counter that is off by one, or a sample point that has drifted, shows up as a shifted or corrupted data_o at the very next valid_o strobe. It also moves the parity and stop decisions, so the error pulses show up in the wrong characters. A corrupted history register is visible on hist_o within one tick, through the position of the first 1 after a long low stretch. A wrong break threshold or a wrong re-arm condition shows as brk_o pulsing outside the expected window, one character-time scale after the line falls. A stuck receive state shows within one character as idle_o failing to return high, or as a missing strobe.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  // Break threshold in ticks: (2 << code) characters of char_bits bits
  function automatic int unsigned brk_ticks(input logic [1:0] code,
                                            input int unsigned char_bits,
                                            input int unsigned osr);
    return (32'd2 << code) * char_bits * osr;
  endfunction

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

endpackage

// File: rtl/uart_rx_nco.sv
module uart_rx_nco #(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] acc_q;
  logic [RATE_W:0]   sum_w;

  assign sum_w = {1'b0, acc_q} + {1'b0, rate_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= sum_w[RATE_W-1:0];
      tick_o <= sum_w[RATE_W];
    end
  end
endmodule

// File: rtl/uart_rx_cond.sv
module uart_rx_cond
  import uart_rx_pkg::*;
#(
  parameter int SYNC_N = 2,
  parameter int HIST_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              filt_en_i,
  input  logic              lpbk_en_i,
  input  logic              tick_i,
  output logic              rx_o,
  output logic [HIST_W-1:0] hist_o
);
  logic [SYNC_N-1:0] sync_q;
  logic [2:0]        win_q;
  logic              filt_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], line_i};
      win_q  <= {win_q[1:0], sync_q[SYNC_N-1]};
    end
  end

  assign filt_w = filt_en_i ? maj3(win_q) : win_q[0];
  assign rx_o   = lpbk_en_i ? 1'b1 : filt_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_o <= '1;
    else if (tick_i) hist_o <= {hist_o[HIST_W-2:0], rx_o};
  end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int CHAR_BITS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] lvl_i,
  output logic       brk_o
);
  localparam int MAX_T = 16 * CHAR_BITS * OSR;
  localparam int CW    = $clog2(MAX_T + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr_w;
  logic          done_q;

  assign thr_w = CW'(brk_ticks(lvl_i, CHAR_BITS, OSR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      brk_o <= 1'b0;
      if (!en_i || rx_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (tick_i && !done_q) begin
        if (cnt_q == thr_w - 1'b1) begin
          brk_o  <= 1'b1;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_deframe.sv
module uart_rx_deframe
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              idle_o
);
  localparam int CW  = $clog2(OSR);
  localparam int BIW = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BIW-1:0]    bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              perr_q;
  logic              mid_w, full_w, last_w;

  function automatic logic want_par(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  assign mid_w  = (cnt_q == CW'(OSR/2 - 1));
  assign full_w = (cnt_q == CW'(OSR - 1));
  assign last_w = (bit_q == BIW'(DATA_W - 1));
  assign idle_o = (state_q == RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      perr_q    <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rx_i) state_q <= RX_START;
          end
          RX_START: begin
            if (mid_w) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              perr_q  <= 1'b0;
              state_q <= rx_i ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (full_w) begin
              cnt_q <= '0;
              sh_q  <= {rx_i, sh_q[DATA_W-1:1]};
              if (last_w) state_q <= par_en_i ? RX_PAR : RX_STOP;
              else bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_PAR: begin
            if (full_w) begin
              cnt_q   <= '0;
              perr_q  <= (rx_i != want_par(sh_q, par_odd_i));
              state_q <= RX_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (full_w) begin
              cnt_q     <= '0;
              valid_o   <= 1'b1;
              data_o    <= sh_q;
              par_err_o <= par_en_i & perr_q;
              frm_err_o <= ~rx_i;
              state_q   <= rx_i ? RX_IDLE : RX_HOLD;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_HOLD: begin
            if (rx_i) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RATE_W    = 16,
  parameter int OSR       = 16,
  parameter int HIST_W    = 16,
  parameter int SYNC_N    = 2,
  parameter int CHAR_BITS = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              line_i,
  input  logic              filt_en_i,
  input  logic              lpbk_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [1:0]        brk_lvl_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o,
  output logic              idle_o,
  output logic [HIST_W-1:0] hist_o,
  output logic              lpbk_tx_o
);
  logic tick_w;
  logic rx_w;

  assign lpbk_tx_o = lpbk_en_i ? line_i : 1'b1;

  uart_rx_nco #(.RATE_W(RATE_W)) u_nco (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rate_i(rate_i),
    .tick_o(tick_w)
  );

  uart_rx_cond #(.SYNC_N(SYNC_N), .HIST_W(HIST_W)) u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .filt_en_i(filt_en_i),
    .lpbk_en_i(lpbk_en_i),
    .tick_i   (tick_w),
    .rx_o     (rx_w),
    .hist_o   (hist_o)
  );

  uart_rx_brk #(.OSR(OSR), .CHAR_BITS(CHAR_BITS)) u_brk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_i),
    .tick_i(tick_w),
    .rx_i  (rx_w),
    .lvl_i (brk_lvl_i),
    .brk_o (brk_o)
  );

  uart_rx_deframe #(.DATA_W(DATA_W), .OSR(OSR)) u_deframe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en_i),
    .tick_i   (tick_w),
    .rx_i     (rx_w),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .par_err_o(par_err_o),
    .frm_err_o(frm_err_o),
    .idle_o   (idle_o)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int HIST_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              tick_i,
  input logic              rx_view_i,
  input logic [HIST_W-1:0] hist_i,
  input logic              valid_i,
  input logic              par_err_i,
  input logic              frm_err_i,
  input logic              brk_i,
  input logic              idle_i
);
  a_r2_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  a_r4_par_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_i |-> valid_i);

  a_r5_frm_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_i |-> valid_i);

  a_r6_brk_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !brk_i);

  a_r8_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> hist_i == {$past(hist_i[HIST_W-2:0]), $past(rx_view_i)});

  a_r10_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> idle_i);

  a_r11_valid_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !$past(idle_i));
endmodule

bind uart_rx_core uart_rx_chk #(.HIST_W(HIST_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rx_en_i  (rx_en_i),
  .tick_i   (tick_w),
  .rx_view_i(rx_w),
  .hist_i   (hist_o),
  .valid_i  (valid_o),
  .par_err_i(par_err_o),
  .frm_err_i(frm_err_o),
  .brk_i    (brk_o),
  .idle_i   (idle_o)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {data[7:0], par_en, par_odd, bad_par, bad_stop, exp_perr, exp_ferr}
  localparam logic [13:0] VEC [NVEC] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h7E, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b1, line = 1'b1, filt_en = 1'b0, lpbk_en = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic [1:0]  brk_lvl = 2'd0;
  logic [15:0] rate = 16'hFFFF;
  logic [7:0]  data;
  logic valid, perr, ferr, brk, idle, lpbk_tx;
  logic [15:0] hist;

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_brk = 0;
  logic saw_busy = 1'b0;
  logic [7:0] cap_data = '0;
  logic cap_perr = 1'b0, cap_ferr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_core dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .line_i(line),
    .filt_en_i(filt_en), .lpbk_en_i(lpbk_en), .par_en_i(par_en),
    .par_odd_i(par_odd), .brk_lvl_i(brk_lvl), .rate_i(rate),
    .data_o(data), .valid_o(valid), .par_err_o(perr), .frm_err_o(ferr),
    .brk_o(brk), .idle_o(idle), .hist_o(hist), .lpbk_tx_o(lpbk_tx)
  );

  always @(negedge clk) begin
    if (valid) begin
      n_valid++;
      cap_data = data;
      cap_perr = perr;
      cap_ferr = ferr;
    end
    if (brk) n_brk++;
    if (!idle) saw_busy = 1'b1;
  end

  task automatic check(input string req, input logic ok, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic pe, input logic po,
                      input logic bad_par, input logic bad_stop, input int bclk);
    line = 1'b0;
    repeat (bclk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      line = d[i];
      repeat (bclk) @(negedge clk);
    end
    if (pe) begin
      line = (^d) ^ po ^ bad_par;
      repeat (bclk) @(negedge clk);
    end
    line = ~bad_stop;
    repeat (bclk) @(negedge clk);
    line = 1'b1;
    repeat (3 * bclk) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 idle", idle === 1'b1, idle, 1);
    check("R1 strobes", {valid, perr, ferr, brk} === 4'b0, {valid, perr, ferr, brk}, 0);
    check("R1 hist", hist === 16'hFFFF, hist, 16'hFFFF);
    check("R9 loop out off", lpbk_tx === 1'b1, lpbk_tx, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R4 R5 vector table
    for (int v = 0; v < NVEC; v++) begin
      base = n_valid;
      par_en  = VEC[v][5];
      par_odd = VEC[v][4];
      send(VEC[v][13:6], VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2], 16);
      check("R2 one strobe", n_valid == base + 1, n_valid - base, 1);
      check("R2 data", cap_data === VEC[v][13:6], cap_data, VEC[v][13:6]);
      check("R4 parity err", cap_perr === VEC[v][1], cap_perr, VEC[v][1]);
      check("R5 frame err", cap_ferr === VEC[v][0], cap_ferr, VEC[v][0]);
    end
    check("R11 busy seen", saw_busy === 1'b1, saw_busy, 1);
    check("R11 idle after", idle === 1'b1, idle, 1);
    par_en = 1'b0;

    // R3 slower rate word: 32 clocks per bit
    rate = 16'h8000;
    base = n_valid;
    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 32);
    check("R3 strobe", n_valid == base + 1, n_valid - base, 1);
    check("R3 data", cap_data === 8'h5A, cap_data, 8'h5A);
    rate = 16'hFFFF;

    // R10 receive disabled
    rx_en = 1'b0;
    saw_busy = 1'b0;
    base = n_valid;
    send(8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    check("R10 no strobe", n_valid == base, n_valid - base, 0);
    check("R10 stays idle", saw_busy === 1'b0, saw_busy, 0);
    rx_en = 1'b1;

    // R9 line loopback
    lpbk_en = 1'b1;
    line = 1'b0; #1;
    check("R9 forward 0", lpbk_tx === 1'b0, lpbk_tx, 0);
    line = 1'b1; #1;
    check("R9 forward 1", lpbk_tx === 1'b1, lpbk_tx, 1);
    @(negedge clk);
    saw_busy = 1'b0;
    base = n_valid;
    send(8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    check("R9 no strobe", n_valid == base, n_valid - base, 0);
    check("R9 idle view", saw_busy === 1'b0, saw_busy, 0);
    line = 1'b0;
    repeat (40) @(negedge clk);
    check("R9 hist ones", hist === 16'hFFFF, hist, 16'hFFFF);
    line = 1'b1;
    lpbk_en = 1'b0;
    repeat (10) @(negedge clk);

    // R7 glitch filter
    filt_en = 1'b1;
    saw_busy = 1'b0;
    line = 1'b0; @(negedge clk); line = 1'b1;
    repeat (30) @(negedge clk);
    check("R7 filtered glitch", saw_busy === 1'b0, saw_busy, 0);
    filt_en = 1'b0;
    base = n_valid;
    line = 1'b0; @(negedge clk); line = 1'b1;
    repeat (40) @(negedge clk);
    check("R7 raw glitch starts", saw_busy === 1'b1, saw_busy, 1);
    check("R7 false start dropped", n_valid == base && idle === 1'b1, n_valid - base, 0);

    // R8 history order
    rx_en = 1'b0;
    line = 1'b0;
    repeat (40) @(negedge clk);
    check("R8 hist zero", hist === 16'h0000, hist, 0);
    line = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (hist != 16'h0000) break;
    end
    check("R8 newest in bit0", hist === 16'h0001, hist, 16'h0001);
    repeat (30) @(negedge clk);
    check("R8 hist refilled", hist === 16'hFFFF, hist, 16'hFFFF);
    rx_en = 1'b1;
    repeat (5) @(negedge clk);

    // R6 break, 2 characters = 320 ticks
    brk_lvl = 2'd0;
    base = n_brk;
    line = 1'b0;
    repeat (300) @(negedge clk);
    check("R6 no early break", n_brk == base, n_brk - base, 0);
    repeat (60) @(negedge clk);
    check("R6 break at 2 chars", n_brk == base + 1, n_brk - base, 1);
    repeat (540) @(negedge clk);
    check("R6 single pulse", n_brk == base + 1, n_brk - base, 1);
    line = 1'b1;
    repeat (40) @(negedge clk);
    // 4 characters = 640 ticks
    brk_lvl = 2'd1;
    base = n_brk;
    line = 1'b0;
    repeat (600) @(negedge clk);
    check("R6 no break before 4 chars", n_brk == base, n_brk - base, 0);
    repeat (100) @(negedge clk);
    check("R6 break at 4 chars", n_brk == base + 1, n_brk - base, 1);
    line = 1'b1;
    repeat (40) @(negedge clk);
    check("R5 hold released", idle === 1'b1, idle, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule